// File: doc/BRIEF.md
# Reference Clock Loss Detector

This block watches one slow reference clock of nominally 8 kHz (125 µs period) and raises a loss flag when that clock stops toggling. The pin is asynchronous to the block. It passes through a synchronizer chain, and the rising edges of the synchronized level count as activity. Time in the system clock domain is cut into fixed windows of `WIN_CYCLES` clocks, counted from the release of reset. The flag is judged only at the end of each window. A run of empty windows declares a loss. The first window that holds an edge clears it.

With the default 2 ms window and two empty windows needed, a stopped reference is flagged between 4 ms and 6 ms after its last edge. A reference that comes back is cleared at most one window, plus the synchronizer latency, after its first edge. A system with two redundant references uses one instance per reference. The window length is a parameter, so a short window can stand in for the real one.

Top module: `ref_loss_detector`

## Requirements
- R1: While `rst` is high and after it is released, `ref_lost` is 1. It stays 1 until the end of a window that contains activity. A reset applied in mid-run sets it to 1 again, and activity from before the reset is forgotten.
- R2: A rising edge of `ref_in` counts as activity after a synchronizer of `SYNC_STAGES` flops (default 2). A high pulse only one system clock long is enough. The edge counts toward the window in which the clock edge `SYNC_STAGES`+1 clocks after the pin change falls.
- R3: `ref_lost` falls at the window boundary that ends the first window containing activity. This includes an edge that is counted on the last clock of that window.
- R4: `ref_lost` rises at the boundary that ends the `MISS_WINDOWS`-th consecutive window without activity (default 2).
- R5: Fewer than `MISS_WINDOWS` consecutive empty windows leave a clear flag clear.
- R6: A low-going pulse on a line that rests high counts as activity through its trailing rising edge. A falling edge on its own does not count.
- R7: A pin held at a steady level, high or low, is treated as a lost reference.
- R8: `ref_lost` changes only on window boundaries. A boundary falls on every `WIN_CYCLES`-th rising clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous reference clock pin |
| ref_lost | output | 1 | Registered loss flag, 1 = reference missing |

## Verification
The bench aims at edges close to a window boundary. One test uses a pulse whose synchronized edge lands on the last clock of a window, and another uses a pulse one clock later that must count in the next window. A design with the wrong synchronizer latency, or one that drops the edge seen on the boundary clock, clears a window late or early. A single empty window between active windows catches a design that declares loss after one window. A steady-high line and a lone falling edge catch a detector that looks at level or at both edges. A reset in mid-run catches a design that keeps a stale "seen" bit or miss count across reset.

// File: rtl/lor_pkg.sv
package lor_pkg;

    typedef enum logic {
        REF_PRESENT = 1'b0,
        REF_MISSING = 1'b1
    } ref_state_e;

    typedef struct packed {
        logic level;
        logic rise;
    } edge_info_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lor_edge_sense.sv
module lor_edge_sense
    import lor_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_in,
    output edge_info_t info
);
    localparam int unsigned TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain;
    logic                   last_level;

    // Synchronizer chain, one flop per stage
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= ref_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_level <= 1'b0;
        else     last_level <= chain[TOP];
    end

    assign info.level = chain[TOP];
    assign info.rise  = chain[TOP] & ~last_level;

endmodule

// File: rtl/lor_window_timer.sv
module lor_window_timer
    import lor_pkg::*;
#(
    parameter int unsigned WIN_CYCLES = 500_000
) (
    input  logic clk,
    input  logic rst,
    output logic win_end
);
    localparam int unsigned    CW   = cnt_width(WIN_CYCLES);
    localparam logic [CW-1:0]  LAST = CW'(WIN_CYCLES - 1);

    logic [CW-1:0] cnt;

    assign win_end = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (win_end) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/lor_verdict.sv
module lor_verdict
    import lor_pkg::*;
#(
    parameter int unsigned MISS_WINDOWS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic win_end,
    output logic lost
);
    localparam int unsigned   MW       = $clog2(MISS_WINDOWS + 1);
    localparam logic [MW-1:0] MISS_MAX = MW'(MISS_WINDOWS);

    logic          seen;
    logic          active;
    logic [MW-1:0] miss;
    logic [MW-1:0] miss_nx;
    ref_state_e    state;

    // An edge on the boundary clock still belongs to the closing window
    assign active = seen | rise;

    always_comb begin
        miss_nx = (miss == MISS_MAX) ? miss : miss + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen  <= 1'b0;
            miss  <= MISS_MAX;
            state <= REF_MISSING;
        end else begin
            seen <= win_end ? 1'b0 : active;
            if (win_end) begin
                if (active) begin
                    miss  <= '0;
                    state <= REF_PRESENT;
                end else begin
                    miss <= miss_nx;
                    if (miss_nx == MISS_MAX) state <= REF_MISSING;
                end
            end
        end
    end

    assign lost = (state == REF_MISSING);

endmodule

// File: rtl/ref_loss_detector.sv
module ref_loss_detector
    import lor_pkg::*;
#(
    parameter int unsigned WIN_CYCLES   = 500_000,
    parameter int unsigned MISS_WINDOWS = 2,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    output logic ref_lost
);
    edge_info_t sense;
    logic       win_end;

    lor_edge_sense #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sense (
        .clk   (clk),
        .rst   (rst),
        .ref_in(ref_in),
        .info  (sense)
    );

    lor_window_timer #(
        .WIN_CYCLES(WIN_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .win_end(win_end)
    );

    lor_verdict #(
        .MISS_WINDOWS(MISS_WINDOWS)
    ) u_verdict (
        .clk    (clk),
        .rst    (rst),
        .rise   (sense.rise),
        .win_end(win_end),
        .lost   (ref_lost)
    );

endmodule

// File: rtl/lor_checker.sv
module lor_checker (
    input logic clk,
    input logic rst,
    input logic rise,
    input logic win_end,
    input logic ref_lost
);
    // R1
    a_r1_reset_sets_flag: assert property (@(posedge clk) rst |=> ref_lost);

    // R2
    a_r2_rise_is_one_cycle: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

    // R3
    a_r3_edge_at_boundary_clears: assert property (@(posedge clk) disable iff (rst)
        (win_end && rise) |=> !ref_lost);

    // R4
    a_r4_set_only_after_empty_window: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_lost) |-> ($past(win_end) && !$past(rise)));

    // R8
    a_r8_flag_steady_inside_window: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> $stable(ref_lost));

endmodule

bind ref_loss_detector lor_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .rise    (sense.rise),
    .win_end (win_end),
    .ref_lost(ref_lost)
);

// File: tb/ref_loss_detector_tb.sv
`timescale 1ns/1ps
module ref_loss_detector_tb;

    localparam int unsigned W    = 20;
    localparam int unsigned MISS = 2;
    localparam int          NVEC = 25;

    // Window modes: 0 low, 1 high pulse at i=2, 2 low pulse at i=2 (rest high),
    // 3 held high, 4 toggling, 5 late pulse (counted last clock), 6 pulse counted next window
    // Vector = {mode[2:0], expected flag after the window}
    localparam logic [3:0] VEC [NVEC] = '{
        {3'd0,1'b1}, {3'd1,1'b0}, {3'd1,1'b0}, {3'd0,1'b0}, {3'd1,1'b0},
        {3'd0,1'b0}, {3'd0,1'b1}, {3'd0,1'b1}, {3'd6,1'b1}, {3'd0,1'b0},
        {3'd0,1'b0}, {3'd0,1'b1}, {3'd5,1'b0}, {3'd3,1'b0}, {3'd3,1'b0},
        {3'd3,1'b1}, {3'd2,1'b0}, {3'd3,1'b0}, {3'd3,1'b1}, {3'd1,1'b0},
        {3'd3,1'b0}, {3'd0,1'b0}, {3'd0,1'b1}, {3'd4,1'b0}, {3'd4,1'b0}
    };

    logic clk = 1'b0;
    logic rst;
    logic ref_in;
    logic ref_lost;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    ref_loss_detector #(
        .WIN_CYCLES  (W),
        .MISS_WINDOWS(MISS),
        .SYNC_STAGES (2)
    ) u_dut (
        .clk     (clk),
        .rst     (rst),
        .ref_in  (ref_in),
        .ref_lost(ref_lost)
    );

    function automatic logic pin_level(input int mode, input int i);
        case (mode)
            0: return 1'b0;
            1: return (i == 2);
            2: return (i != 2);
            3: return 1'b1;
            4: return ((i % 8) >= 4);
            5: return (i == int'(W) - 3);
            6: return (i == int'(W) - 2);
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: ref_lost=%0b expected %0b at %0t", req, act, expv, $time);
        end
    endtask

    // Entered at the negedge right before the first clock of a window
    task automatic run_window(input int mode, input logic expv, input string req);
        logic start_flag;
        bit   moved;
        start_flag = ref_lost;
        moved = 0;
        for (int i = 0; i < int'(W); i++) begin
            ref_in = pin_level(mode, i);
            @(negedge clk);
            if (i < int'(W) - 1 && ref_lost !== start_flag) moved = 1;
        end
        checks++;
        if (moved) begin
            errors++;
            $display("FAIL R8: ref_lost=%0b expected %0b held inside window", ~start_flag, start_flag);
        end
        check(req, ref_lost, expv);
    endtask

    initial begin
        rst    = 1'b1;
        ref_in = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 during reset", ref_lost, 1'b1);
        rst = 1'b0;
        check("R1 after release", ref_lost, 1'b1);

        // R2 R3 R4 R5 R6 R7 via the vector table
        for (int v = 0; v < NVEC; v++) begin
            run_window(int'(VEC[v][3:1]), VEC[v][0], $sformatf("R3/R4/R5/R6/R7 vector %0d", v));
        end

        // R1: mid-run reset brings the flag back and forgets activity
        ref_in = 1'b0;
        rst    = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", ref_lost, 1'b1);
        @(negedge clk);
        rst = 1'b0;
        run_window(0, 1'b1, "R1 no activity after reset");
        run_window(1, 1'b0, "R2 one-clock pulse after reset");
        run_window(5, 1'b0, "R3 edge on last clock");
        run_window(3, 1'b0, "R7 rising into high");
        run_window(3, 1'b0, "R5 one empty window");
        run_window(3, 1'b1, "R7 steady high");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run incomplete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule